// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is an eight-pin general-purpose I/O port controlled through a byte-wide register interface. It holds two registers. The level register latches every write and supplies the value driven on output pins. The mode register chooses, per pin, whether the pin is an input (0) or an output (1). Reading the level register gives, for each pin, either the latched bit or the sampled pin level, depending on that pin's mode bit.

Two per-pin ownership inputs sit beside the registers. An analog claim takes the pin away from all digital use: its read bit is 0 and it is never driven. A peripheral claim hands the pin's drive enable and drive value to the peripheral's own inputs. The analog claim wins over the peripheral claim. The parameter `RSVD_MASK` marks bit positions that are not implemented. Those bits store nothing, read as 0 and never drive. Pin inputs pass through a two-flop synchronizer before they reach the read path.

The register read path is combinational from `addr`, and a write takes effect at the clock edge on which `wr_en` is sampled high. The block has no state machine. Its only decoded "states" are the three register selections: `SEL_DATA` (offset 2), `SEL_DIR` (offset 3) and `SEL_NONE` (any other offset). The decoded selection moves between them only when `addr` changes.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the level and mode registers hold all zeros, so every pin has `pad_oe` = 0 and both registers read back as 0 while the pins are low.
- R2: A write with `addr` = 2 latches `wdata` into every implemented bit of the level register, whatever each pin's mode. For a pin whose mode bit is 1, a read at offset 2 returns the latched bit.
- R3: A write with `addr` = 3 stores the mode bits, and a read at offset 3 returns them. Mode bit 0 means input and mode bit 1 means output.
- R4: For a pin with mode 1 and no analog or peripheral claim, `pad_oe` is 1 and `pad_out` equals the latched level bit.
- R5: For a pin with mode 0, bit n of a read at offset 2 equals `pin_in[n]` as sampled two rising edges earlier. It shows the old level after one edge and the new level after the second edge.
- R6: For a pin with `per_sel` = 1 and no analog claim, `pad_oe` and `pad_out` follow `per_oe` and `per_out`. When that pin's mode is 0, a level read still returns the synchronized pin level.
- R7: For a pin with `ana_sel` = 1, the read bit at offset 2 is 0, `pad_oe` is 0 and `pad_out` is 0, whatever the mode, level and peripheral inputs.
- R8: Bit positions set in `RSVD_MASK` ignore writes, read as 0 at every offset, and keep `pad_oe` and `pad_out` at 0.
- R9: A write to any offset other than 2 or 3 changes no register, and a read there returns 0.
- R10: The block imposes no order on writes. A level written while a pin is an input is driven at once when the mode bit is later set to 1. A read in the same cycle as a write returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | PORT_W | Write data |
| rdata | output | PORT_W | Read data for `addr`, combinational |
| pin_in | input | PORT_W | Pin levels from the pads, asynchronous |
| ana_sel | input | PORT_W | Per-pin analog claim |
| per_sel | input | PORT_W | Per-pin peripheral claim |
| per_oe | input | PORT_W | Peripheral drive enable per pin |
| per_out | input | PORT_W | Peripheral drive value per pin |
| pad_oe | output | PORT_W | Pad output enable per pin |
| pad_out | output | PORT_W | Pad output value per pin |

## Verification
Two functions can land on the same pin in the same cycle: the analog claim and the peripheral drive. The bench raises `ana_sel` and `per_sel` together on pin 0, with the peripheral asking to drive a 1. It then checks that the pad stays undriven and that the read bit is 0. A register write and a read of that same register can also fall in one cycle. The bench holds `addr` at 2 with `wr_en` high and reads `rdata` before the edge, where it expects the old value, and again after the edge, where it expects the new value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;

    localparam int DEF_DATA_OFS = 2;
    localparam int DEF_DIR_OFS  = 3;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_s
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= pin_i;
            stage2_q <= stage1_q;
        end
    end

    assign pin_s = stage2_q;

    // age counter: the two-edge history check is valid once both stages are filled
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               age_q <= '0;
        else if (age_q != 2'd2)   age_q <= age_q + 2'd1;
    end

    p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (pin_s == $past(pin_i, 2)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int               W        = 8,
    parameter int               ADDR_W   = 2,
    parameter logic [W-1:0]     RSVD     = '0,
    parameter int               DATA_OFS = DEF_DATA_OFS,
    parameter int               DIR_OFS  = DEF_DIR_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output reg_sel_e          sel,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      dir_q
);

    localparam logic [ADDR_W-1:0] DATA_A = DATA_OFS[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] DIR_A  = DIR_OFS[ADDR_W-1:0];
    localparam logic [W-1:0]      IMPL   = ~RSVD;

    always_comb begin
        if (addr == DATA_A)      sel = SEL_DATA;
        else if (addr == DIR_A)  sel = SEL_DIR;
        else                     sel = SEL_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_DATA: data_q <= wdata & IMPL;
                SEL_DIR:  dir_q  <= wdata & IMPL;
                SEL_NONE: ;
                default:  ;
            endcase
        end
    end

    p_level_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == DATA_A) |=> (data_q == ($past(wdata) & IMPL)));

    p_mode_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == DIR_A) |=> (dir_q == ($past(wdata) & IMPL)));

    p_other_ofs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != DATA_A && addr != DIR_A) |=> ($stable(data_q) && $stable(dir_q)));

    p_rsvd_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_q | dir_q) & RSVD) == '0);

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int           W    = 8,
    parameter logic [W-1:0] RSVD = '0
) (
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pin_s,
    input  logic [W-1:0] ana_sel,
    input  logic [W-1:0] per_sel,
    input  logic [W-1:0] per_oe,
    input  logic [W-1:0] per_out,
    output logic [W-1:0] level_rd,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (RSVD[i]) begin : g_rsvd
            assign level_rd[i] = 1'b0;
            assign pad_oe[i]   = 1'b0;
            assign pad_out[i]  = 1'b0;
        end else begin : g_impl
            always_comb begin
                if (ana_sel[i]) begin
                    level_rd[i] = 1'b0;
                    pad_oe[i]   = 1'b0;
                    pad_out[i]  = 1'b0;
                end else begin
                    level_rd[i] = dir_q[i] ? data_q[i] : pin_s[i];
                    if (per_sel[i]) begin
                        pad_oe[i]  = per_oe[i];
                        pad_out[i] = per_out[i];
                    end else begin
                        pad_oe[i]  = dir_q[i];
                        pad_out[i] = data_q[i];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int                PORT_W    = 8,
    parameter int                ADDR_W    = 2,
    parameter logic [PORT_W-1:0] RSVD_MASK = '0,
    parameter int                DATA_OFS  = DEF_DATA_OFS,
    parameter int                DIR_OFS   = DEF_DIR_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] ana_sel,
    input  logic [PORT_W-1:0] per_sel,
    input  logic [PORT_W-1:0] per_oe,
    input  logic [PORT_W-1:0] per_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out
);

    reg_sel_e          sel;
    logic [PORT_W-1:0] data_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] pin_s;
    logic [PORT_W-1:0] level_rd;

    gpio_regs #(
        .W        (PORT_W),
        .ADDR_W   (ADDR_W),
        .RSVD     (RSVD_MASK),
        .DATA_OFS (DATA_OFS),
        .DIR_OFS  (DIR_OFS)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .sel    (sel),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    gpio_sync #(
        .W (PORT_W)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_in),
        .pin_s (pin_s)
    );

    gpio_pin_mux #(
        .W    (PORT_W),
        .RSVD (RSVD_MASK)
    ) u_mux (
        .data_q   (data_q),
        .dir_q    (dir_q),
        .pin_s    (pin_s),
        .ana_sel  (ana_sel),
        .per_sel  (per_sel),
        .per_oe   (per_oe),
        .per_out  (per_out),
        .level_rd (level_rd),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out)
    );

    always_comb begin
        unique case (sel)
            SEL_DATA: rdata = level_rd;
            SEL_DIR:  rdata = dir_q;
            SEL_NONE: rdata = '0;
            default:  rdata = '0;
        endcase
    end

    p_ana_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ana_sel & (pad_oe | pad_out)) == '0));

    p_rsvd_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata | pad_oe | pad_out) & RSVD_MASK) == '0);

endmodule

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;

    localparam logic [7:0] RSVD = 8'hC0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] ana_sel = '0;
    logic [7:0] per_sel = '0;
    logic [7:0] per_oe = '0;
    logic [7:0] per_out = '0;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port_regs #(
        .PORT_W    (8),
        .ADDR_W    (2),
        .RSVD_MASK (RSVD)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pin_in  (pin_in),
        .ana_sel (ana_sel),
        .per_sel (per_sel),
        .per_oe  (per_oe),
        .per_out (per_out),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] data;
        logic [7:0] pin;
        logic [7:0] ana;
        logic [7:0] per;
        logic [7:0] poe;
        logic [7:0] pout;
        logic [7:0] exp_rd;
        logic [7:0] exp_oe;
        logic [7:0] exp_out;
    } vec_t;

    // bits 7 and 6 are reserved, so stored values are masked with 8'h3F
    localparam vec_t VECS [5] = '{
        '{8'h00, 8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h25, 8'h00, 8'h3F},
        '{8'h0F, 8'h5A, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h3A, 8'h0F, 8'h1A},
        '{8'h3F, 8'hC3, 8'hFF, 8'h21, 8'h00, 8'h00, 8'h00, 8'h02, 8'h1E, 8'h02},
        '{8'h00, 8'h00, 8'h3C, 8'h01, 8'h06, 8'h07, 8'h05, 8'h3C, 8'h06, 8'h04},
        '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'h30, 8'h10, 8'h20, 8'h3F, 8'h1F, 8'h2F}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] rd;
        repeat (3) @(negedge clk);

        // R1: reset state
        rst_n = 1'b1;
        reg_read(2'd2, rd); check("R1 level read", rd, 8'h00);
        reg_read(2'd3, rd); check("R1 mode read", rd, 8'h00);
        check("R1 pad_oe", pad_oe, 8'h00);

        // vector table: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 5; i++) begin
            ana_sel = '0; per_sel = '0;
            reg_write(2'd2, VECS[i].data);
            reg_write(2'd3, VECS[i].dir);
            pin_in  = VECS[i].pin;
            ana_sel = VECS[i].ana;
            per_sel = VECS[i].per;
            per_oe  = VECS[i].poe;
            per_out = VECS[i].pout;
            repeat (3) @(negedge clk);
            reg_read(2'd2, rd);
            check($sformatf("R2/R5/R7 vec%0d level read", i), rd, VECS[i].exp_rd);
            check($sformatf("R4/R6/R7 vec%0d pad_oe", i), pad_oe, VECS[i].exp_oe);
            check($sformatf("R4/R6/R8 vec%0d pad_out", i), pad_out, VECS[i].exp_out);
            reg_read(2'd3, rd);
            check($sformatf("R3/R8 vec%0d mode read", i), rd, VECS[i].dir & 8'h3F);
        end
        ana_sel = '0; per_sel = '0; per_oe = '0; per_out = '0;

        // R7: analog and peripheral on pin 0 together, peripheral wants to drive 1
        reg_write(2'd3, 8'h01);
        reg_write(2'd2, 8'h01);
        @(negedge clk);
        ana_sel = 8'h01; per_sel = 8'h01; per_oe = 8'h01; per_out = 8'h01;
        reg_read(2'd2, rd);
        check("R7 combined claim read", rd & 8'h01, 8'h00);
        check("R7 combined claim oe", pad_oe & 8'h01, 8'h00);
        check("R7 combined claim out", pad_out & 8'h01, 8'h00);
        ana_sel = '0; per_sel = '0; per_oe = '0; per_out = '0;

        // R5: two-edge latency on an input pin
        reg_write(2'd3, 8'h00);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        addr = 2'd2;
        pin_in = 8'h15;
        @(negedge clk); #1;
        check("R5 after one edge", rdata, 8'h00);
        @(negedge clk); #1;
        check("R5 after two edges", rdata, 8'h15);

        // R8: reserved bits ignore writes
        reg_write(2'd3, 8'hFF);
        reg_read(2'd3, rd);
        check("R8 mode reserved", rd, 8'h3F);
        check("R8 oe reserved", pad_oe & RSVD, 8'h00);

        // R9: other offsets
        reg_write(2'd2, 8'h2A);
        reg_write(2'd0, 8'hFF);
        reg_write(2'd1, 8'h00);
        reg_read(2'd0, rd); check("R9 offset0 read", rd, 8'h00);
        reg_read(2'd1, rd); check("R9 offset1 read", rd, 8'h00);
        reg_read(2'd2, rd); check("R9 level unchanged", rd, 8'h2A);
        reg_read(2'd3, rd); check("R9 mode unchanged", rd, 8'h3F);

        // R10: level written while input, driven once mode set
        reg_write(2'd3, 8'h00);
        reg_write(2'd2, 8'h11);
        check("R10 not driven yet", pad_oe, 8'h00);
        reg_write(2'd3, 8'h3F);
        check("R10 oe after mode", pad_oe, 8'h3F);
        check("R10 out after mode", pad_out, 8'h11);

        // R10: read in the write cycle returns the old value
        @(negedge clk);
        addr = 2'd2; wdata = 8'h22; wr_en = 1'b1;
        #1;
        check("R10 read before edge", rdata, 8'h11);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R10 read after edge", rdata, 8'h22);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule